// File: doc/BRIEF.md
# Round-Robin Shared-Slave Bus Arbiter with Lock

This block lets several Wishbone masters share one slave port. A master asks for the bus by raising CYC and keeps asking for as long as its block cycle runs. The arbiter keeps one owner at a time in a register. It forwards that owner's request fields to the slave and returns the slave's terminations, stall and read data to the owner alone. Masters that do not own the bus see no termination, see a stall and see zero read data.

A grant is never taken away in the middle of a transfer. The owner keeps the bus for as long as its CYC is high. A master that raises LOCK keeps the bus across the gap between successive cycles, even while its CYC is low. The arbiter chooses a new owner only in a cycle where the owner has both CYC and LOCK low, or where there is no owner. The new owner takes the bus at the next clock edge. The choice is round-robin and starts the search at the master after the most recent owner.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer before it reaches the arbitration state.

Top module: `wb_lock_arbiter`

## Requirements
- R1: While reset is held and after it is released with no requests, no master owns the bus. Slave-side CYC and STB are low, every master's ACK, ERR and RTY are low, every master's STALL is high and every master's read data is zero.
- R2: If the bus has no owner and one master raises CYC, that master becomes owner at the first clock edge that samples its CYC high. Before that edge the slave side stays idle.
- R3: While a master owns the bus, the slave side carries that master's CYC, STB, WE, LOCK, address, write data, byte selects, 3-bit cycle type and 2-bit burst type unchanged.
- R4: The slave's ACK, ERR, RTY, STALL and read data go to the owner only. Every other master sees ACK, ERR and RTY low, STALL high and read data zero.
- R5: While the owner holds CYC high, it keeps the bus whatever the other masters request.
- R6: While the owner holds LOCK high, it keeps the bus even with its CYC low. During such a gap the slave sees CYC and STB low and LOCK high.
- R7: In a cycle where the owner has CYC and LOCK both low, or where there is no owner, the next clock edge gives the bus to the first master with CYC high. The search starts at the index after the most recent owner and wraps from the highest index to 0, so the new owner takes over with no idle cycle between. After reset the search starts at master 0.
- R8: While no master owns the bus, every slave-side output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cyc | input | N_MASTERS | Per-master cycle request |
| m_stb | input | N_MASTERS | Per-master strobe |
| m_we | input | N_MASTERS | Per-master write enable |
| m_lock | input | N_MASTERS | Per-master ownership hold |
| m_adr | input | N_MASTERS*ADDR_W | Per-master address, master i in slice i |
| m_wdat | input | N_MASTERS*DATA_W | Per-master write data |
| m_sel | input | N_MASTERS*DATA_W/8 | Per-master byte selects |
| m_cti | input | N_MASTERS*3 | Per-master cycle type |
| m_bte | input | N_MASTERS*2 | Per-master burst type |
| m_ack | output | N_MASTERS | Normal termination to each master |
| m_err | output | N_MASTERS | Error termination to each master |
| m_rty | output | N_MASTERS | Retry termination to each master |
| m_stall | output | N_MASTERS | Stall to each master |
| m_rdat | output | N_MASTERS*DATA_W | Read data to each master |
| s_cyc | output | 1 | Slave cycle |
| s_stb | output | 1 | Slave strobe |
| s_we | output | 1 | Slave write enable |
| s_lock | output | 1 | Slave lock |
| s_adr | output | ADDR_W | Slave address |
| s_wdat | output | DATA_W | Slave write data |
| s_sel | output | DATA_W/8 | Slave byte selects |
| s_cti | output | 3 | Slave cycle type |
| s_bte | output | 2 | Slave burst type |
| s_ack | input | 1 | Slave normal termination |
| s_err | input | 1 | Slave error termination |
| s_rty | input | 1 | Slave retry termination |
| s_stall | input | 1 | Slave stall |
| s_rdat | input | DATA_W | Slave read data |

## Verification
The release of the bus by the owner and a new request from another master can fall in the same cycle, and so can a handover and a slave termination. The bench provokes the first case on purpose: the owner drops CYC, or drops LOCK during a gap, while other masters already hold CYC high. It checks that the next owner is the first requester after the old one, with no idle cycle between them. In a long random phase, requests, locks and slave responses change freely. A behavioural model of ownership predicts every master and slave output in every cycle. Misrouting at a handover edge, such as an ACK that reaches the old owner or a grant one cycle late, shows up as a mismatch.

// File: rtl/wb_arb_pkg.sv
package wb_arb_pkg;
  localparam int CTI_W = 3;
  localparam int BTE_W = 2;

  // index reached by stepping 'step' places past 'base' in a ring of 'n'
  function automatic int unsigned ring_step(int unsigned base, int unsigned step, int unsigned n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/wb_rst_sync.sv
module wb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage1_q   <= 1'b1;
      rst_sync_n <= stage1_q;
    end
  end
endmodule

// File: rtl/wb_rr_pick.sv
module wb_rr_pick #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W = $clog2(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [IDX_W-1:0]     base,
  output logic                 found,
  output logic [IDX_W-1:0]     pick
);
  import wb_arb_pkg::*;

  int unsigned slot;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    slot  = 0;
    for (int k = 1; k <= N_MASTERS; k++) begin
      slot = ring_step(int'(base), k, N_MASTERS);
      if (!found && req[slot]) begin
        found = 1'b1;
        pick  = IDX_W'(slot);
      end
    end
  end
endmodule

// File: rtl/wb_owner_ctl.sv
module wb_owner_ctl #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_sync_n,
  input  logic [N_MASTERS-1:0] m_cyc,
  input  logic [N_MASTERS-1:0] m_lock,
  output logic                 own_vld,
  output logic [IDX_W-1:0]     own_idx
);
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             release_bus;
  logic             any_req;
  logic [IDX_W-1:0] next_idx;

  // idx_q doubles as the most recent owner, which is the round-robin base
  wb_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req   (m_cyc),
    .base  (idx_q),
    .found (any_req),
    .pick  (next_idx)
  );

  always_comb begin
    release_bus = !vld_q || (!m_cyc[idx_q] && !m_lock[idx_q]);
    vld_d = vld_q;
    idx_d = idx_q;
    if (release_bus) begin
      vld_d = any_req;
      if (any_req) idx_d = next_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      idx_q <= IDX_W'(N_MASTERS - 1);
    end else if (release_bus) begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  assign own_vld = vld_q;
  assign own_idx = idx_q;

  assert_hold_cyc_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_q && m_cyc[idx_q]) |=> (vld_q && idx_q == $past(idx_q)));

  assert_hold_lock_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_q && m_lock[idx_q]) |=> (vld_q && idx_q == $past(idx_q)));

  assert_regrant_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((!vld_q || (!m_cyc[idx_q] && !m_lock[idx_q])) && (|m_cyc)) |=> vld_q);
endmodule

// File: rtl/wb_fwd_mux.sv
module wb_fwd_mux #(
  parameter int N_MASTERS = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8,
  localparam int IDX_W = $clog2(N_MASTERS),
  localparam int CTI_W = wb_arb_pkg::CTI_W,
  localparam int BTE_W = wb_arb_pkg::BTE_W
) (
  input  logic                        own_vld,
  input  logic [IDX_W-1:0]            own_idx,
  input  logic [N_MASTERS-1:0]        m_cyc,
  input  logic [N_MASTERS-1:0]        m_stb,
  input  logic [N_MASTERS-1:0]        m_we,
  input  logic [N_MASTERS-1:0]        m_lock,
  input  logic [N_MASTERS*ADDR_W-1:0] m_adr,
  input  logic [N_MASTERS*DATA_W-1:0] m_wdat,
  input  logic [N_MASTERS*SEL_W-1:0]  m_sel,
  input  logic [N_MASTERS*CTI_W-1:0]  m_cti,
  input  logic [N_MASTERS*BTE_W-1:0]  m_bte,
  output logic                        s_cyc,
  output logic                        s_stb,
  output logic                        s_we,
  output logic                        s_lock,
  output logic [ADDR_W-1:0]           s_adr,
  output logic [DATA_W-1:0]           s_wdat,
  output logic [SEL_W-1:0]            s_sel,
  output logic [CTI_W-1:0]            s_cti,
  output logic [BTE_W-1:0]            s_bte
);
  always_comb begin
    s_cyc  = 1'b0;
    s_stb  = 1'b0;
    s_we   = 1'b0;
    s_lock = 1'b0;
    s_adr  = '0;
    s_wdat = '0;
    s_sel  = '0;
    s_cti  = '0;
    s_bte  = '0;
    if (own_vld) begin
      s_cyc  = m_cyc[own_idx];
      s_stb  = m_stb[own_idx];
      s_we   = m_we[own_idx];
      s_lock = m_lock[own_idx];
      s_adr  = m_adr[own_idx*ADDR_W +: ADDR_W];
      s_wdat = m_wdat[own_idx*DATA_W +: DATA_W];
      s_sel  = m_sel[own_idx*SEL_W +: SEL_W];
      s_cti  = m_cti[own_idx*CTI_W +: CTI_W];
      s_bte  = m_bte[own_idx*BTE_W +: BTE_W];
    end
  end
endmodule

// File: rtl/wb_ret_demux.sv
module wb_ret_demux #(
  parameter int N_MASTERS = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(N_MASTERS)
) (
  input  logic                        clk,
  input  logic                        rst_sync_n,
  input  logic                        own_vld,
  input  logic [IDX_W-1:0]            own_idx,
  input  logic                        s_ack,
  input  logic                        s_err,
  input  logic                        s_rty,
  input  logic                        s_stall,
  input  logic [DATA_W-1:0]           s_rdat,
  output logic [N_MASTERS-1:0]        m_ack,
  output logic [N_MASTERS-1:0]        m_err,
  output logic [N_MASTERS-1:0]        m_rty,
  output logic [N_MASTERS-1:0]        m_stall,
  output logic [N_MASTERS*DATA_W-1:0] m_rdat
);
  for (genvar i = 0; i < N_MASTERS; i++) begin : g_port
    logic hit;
    assign hit = own_vld && (own_idx == IDX_W'(i));
    assign m_ack[i]   = hit && s_ack;
    assign m_err[i]   = hit && s_err;
    assign m_rty[i]   = hit && s_rty;
    assign m_stall[i] = hit ? s_stall : 1'b1;
    assign m_rdat[i*DATA_W +: DATA_W] = hit ? s_rdat : '0;
  end

  assert_single_term_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(m_ack | m_err | m_rty));

  assert_single_unstall_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(~m_stall) <= 1));
endmodule

// File: rtl/wb_lock_arbiter.sv
module wb_lock_arbiter #(
  parameter int N_MASTERS = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8,
  localparam int IDX_W = $clog2(N_MASTERS),
  localparam int CTI_W = wb_arb_pkg::CTI_W,
  localparam int BTE_W = wb_arb_pkg::BTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_MASTERS-1:0]        m_cyc,
  input  logic [N_MASTERS-1:0]        m_stb,
  input  logic [N_MASTERS-1:0]        m_we,
  input  logic [N_MASTERS-1:0]        m_lock,
  input  logic [N_MASTERS*ADDR_W-1:0] m_adr,
  input  logic [N_MASTERS*DATA_W-1:0] m_wdat,
  input  logic [N_MASTERS*SEL_W-1:0]  m_sel,
  input  logic [N_MASTERS*CTI_W-1:0]  m_cti,
  input  logic [N_MASTERS*BTE_W-1:0]  m_bte,
  output logic [N_MASTERS-1:0]        m_ack,
  output logic [N_MASTERS-1:0]        m_err,
  output logic [N_MASTERS-1:0]        m_rty,
  output logic [N_MASTERS-1:0]        m_stall,
  output logic [N_MASTERS*DATA_W-1:0] m_rdat,
  output logic                        s_cyc,
  output logic                        s_stb,
  output logic                        s_we,
  output logic                        s_lock,
  output logic [ADDR_W-1:0]           s_adr,
  output logic [DATA_W-1:0]           s_wdat,
  output logic [SEL_W-1:0]            s_sel,
  output logic [CTI_W-1:0]            s_cti,
  output logic [BTE_W-1:0]            s_bte,
  input  logic                        s_ack,
  input  logic                        s_err,
  input  logic                        s_rty,
  input  logic                        s_stall,
  input  logic [DATA_W-1:0]           s_rdat
);
  logic             rst_sync_n;
  logic             own_vld;
  logic [IDX_W-1:0] own_idx;

  wb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wb_owner_ctl #(.N_MASTERS(N_MASTERS)) u_owner (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .m_cyc      (m_cyc),
    .m_lock     (m_lock),
    .own_vld    (own_vld),
    .own_idx    (own_idx)
  );

  wb_fwd_mux #(.N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .own_vld (own_vld),
    .own_idx (own_idx),
    .m_cyc   (m_cyc),
    .m_stb   (m_stb),
    .m_we    (m_we),
    .m_lock  (m_lock),
    .m_adr   (m_adr),
    .m_wdat  (m_wdat),
    .m_sel   (m_sel),
    .m_cti   (m_cti),
    .m_bte   (m_bte),
    .s_cyc   (s_cyc),
    .s_stb   (s_stb),
    .s_we    (s_we),
    .s_lock  (s_lock),
    .s_adr   (s_adr),
    .s_wdat  (s_wdat),
    .s_sel   (s_sel),
    .s_cti   (s_cti),
    .s_bte   (s_bte)
  );

  wb_ret_demux #(.N_MASTERS(N_MASTERS), .DATA_W(DATA_W)) u_ret (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .own_vld    (own_vld),
    .own_idx    (own_idx),
    .s_ack      (s_ack),
    .s_err      (s_err),
    .s_rty      (s_rty),
    .s_stall    (s_stall),
    .s_rdat     (s_rdat),
    .m_ack      (m_ack),
    .m_err      (m_err),
    .m_rty      (m_rty),
    .m_stall    (m_stall),
    .m_rdat     (m_rdat)
  );

  // R8: with no owner the slave must see an idle bus
  assert_idle_slave_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(|(m_stall ^ {N_MASTERS{1'b1}})) && !s_stall) |-> (!s_cyc && !s_stb));
endmodule

// File: tb/wb_lock_arbiter_test.sv
module wb_lock_arbiter_test;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam int FW = 4 + AW + DW + SW + 3 + 2;
  localparam int RW = 4 * N + N * DW;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] cyc, stb, we, lock;
  logic [N*AW-1:0] adr;
  logic [N*DW-1:0] wdat;
  logic [N*SW-1:0] sel;
  logic [N*3-1:0] cti;
  logic [N*2-1:0] bte;
  logic [N-1:0] m_ack, m_err, m_rty, m_stall;
  logic [N*DW-1:0] m_rdat;
  logic s_cyc, s_stb, s_we, s_lock;
  logic [AW-1:0] s_adr;
  logic [DW-1:0] s_wdat;
  logic [SW-1:0] s_sel;
  logic [2:0] s_cti;
  logic [1:0] s_bte;
  logic sl_ack, sl_err, sl_rty, sl_stall;
  logic [DW-1:0] sl_rdat;

  int checks = 0;
  int errors = 0;
  bit in_reset;
  bit done = 1'b0;
  int mdl_own;
  int mdl_last;

  always #4 clk = ~clk;

  wb_lock_arbiter #(.N_MASTERS(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .m_cyc(cyc), .m_stb(stb), .m_we(we), .m_lock(lock),
    .m_adr(adr), .m_wdat(wdat), .m_sel(sel), .m_cti(cti), .m_bte(bte),
    .m_ack(m_ack), .m_err(m_err), .m_rty(m_rty), .m_stall(m_stall), .m_rdat(m_rdat),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_lock(s_lock),
    .s_adr(s_adr), .s_wdat(s_wdat), .s_sel(s_sel), .s_cti(s_cti), .s_bte(s_bte),
    .s_ack(sl_ack), .s_err(sl_err), .s_rty(sl_rty), .s_stall(sl_stall), .s_rdat(sl_rdat)
  );

  // behavioural ownership model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_own  = -1;
      mdl_last = N - 1;
    end else if (mdl_own < 0 || (!cyc[mdl_own] && !lock[mdl_own])) begin
      int nxt;
      nxt = -1;
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (mdl_last + k) % N;
        if (nxt < 0 && cyc[c]) nxt = c;
      end
      mdl_own = nxt;
      if (nxt >= 0) mdl_last = nxt;
    end
  end

  task automatic check_vec(string tag, string what, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [FW-1:0] fexp;
    logic [RW-1:0] rexp;
    string ftag;
    string rtag;
    fexp = '0;
    rexp = '0;
    for (int i = 0; i < N; i++) rexp[N+i] = 1'b1;
    if (mdl_own >= 0) begin
      int o;
      o = mdl_own;
      fexp = {cyc[o], stb[o], we[o], lock[o], adr[o*AW +: AW], wdat[o*DW +: DW],
              sel[o*SW +: SW], cti[o*3 +: 3], bte[o*2 +: 2]};
      rexp[3*N + o] = sl_ack;
      rexp[2*N + o] = sl_err;
      rexp[N*DW + N + o] = sl_rty;
      rexp[N + o] = sl_stall;
    end
    // layout: {ack, err, rty, stall, rdat}
    begin
      logic [N-1:0] a, e, r, s;
      logic [N*DW-1:0] d;
      a = '0; e = '0; r = '0; s = '1; d = '0;
      if (mdl_own >= 0) begin
        a[mdl_own] = sl_ack;
        e[mdl_own] = sl_err;
        r[mdl_own] = sl_rty;
        s[mdl_own] = sl_stall;
        d[mdl_own*DW +: DW] = sl_rdat;
      end
      rexp = {a, e, r, s, d};
    end
    ftag = in_reset ? "R1" : (mdl_own >= 0 ? "R3" : "R8");
    rtag = in_reset ? "R1" : "R4";
    check_vec(ftag, "slave side", RW'({s_cyc, s_stb, s_we, s_lock, s_adr, s_wdat, s_sel, s_cti, s_bte}), RW'(fexp));
    check_vec(rtag, "master returns", {m_ack, m_err, m_rty, m_stall, m_rdat}, rexp);
  endtask

  // drive at the falling edge, compare shortly after
  task automatic step();
    @(negedge clk);
    #1;
    compare_model();
  endtask

  task automatic expect_owner(int exp, string tag);
    logic [N-1:0] want;
    want = '1;
    if (exp >= 0) want[exp] = 1'b0;
    check_vec(tag, "owner seen via stall", RW'(m_stall), RW'(want));
  endtask

  task automatic randomize_fields();
    for (int i = 0; i < N; i++) begin
      adr[i*AW +: AW]  = $urandom;
      wdat[i*DW +: DW] = $urandom;
      sel[i*SW +: SW]  = SW'($urandom);
      cti[i*3 +: 3]    = 3'($urandom);
      bte[i*2 +: 2]    = 2'($urandom);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_reset = 1'b1;
    cyc = '0; stb = '0; we = '0; lock = '0;
    adr = '0; wdat = '0; sel = '0; cti = '0; bte = '0;
    sl_ack = 1'b0; sl_err = 1'b0; sl_rty = 1'b0; sl_stall = 1'b0; sl_rdat = 32'hA5A5_0001;
    randomize_fields();
    repeat (3) step();
    expect_owner(-1, "R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) step();
    in_reset = 1'b0;
    expect_owner(-1, "R1");

    // R2: single request granted at the first edge that sees it
    @(negedge clk) begin cyc[2] = 1'b1; stb[2] = 1'b1; end
    #1 compare_model(); expect_owner(-1, "R2");
    step(); expect_owner(2, "R2");
    sl_ack = 1'b1; step(); sl_ack = 1'b0;

    // R5: others request while 2 holds CYC
    @(negedge clk) begin cyc[0] = 1'b1; cyc[1] = 1'b1; cyc[3] = 1'b1; end
    #1 compare_model();
    repeat (3) step();
    expect_owner(2, "R5");

    // R7: release goes to the next index after 2, then wraps
    @(negedge clk) begin cyc[2] = 1'b0; stb[2] = 1'b0; end
    #1 compare_model(); expect_owner(2, "R7");
    step(); expect_owner(3, "R7");
    @(negedge clk) cyc[3] = 1'b0;
    #1 compare_model();
    step(); expect_owner(0, "R7");
    @(negedge clk) cyc[0] = 1'b0;
    #1 compare_model();
    step(); expect_owner(1, "R7");

    // R6: owner 1 drops CYC but keeps LOCK while others wait
    @(negedge clk) begin cyc[1] = 1'b0; lock[1] = 1'b1; cyc[0] = 1'b1; cyc[3] = 1'b1; end
    #1 compare_model();
    repeat (3) step();
    expect_owner(1, "R6");
    checks++;
    if (s_cyc !== 1'b0 || s_lock !== 1'b1) begin
      errors++;
      $display("FAIL R6 lock gap: got cyc=%b lock=%b expected cyc=0 lock=1", s_cyc, s_lock);
    end
    @(negedge clk) lock[1] = 1'b0;
    #1 compare_model();
    step(); expect_owner(3, "R7");

    // R8: everyone leaves
    @(negedge clk) begin cyc = '0; end
    #1 compare_model();
    step(); expect_owner(-1, "R8");
    checks++;
    if (s_cyc !== 1'b0 || s_adr !== '0) begin
      errors++;
      $display("FAIL R8 idle slave: got cyc=%b adr=%h expected 0", s_cyc, s_adr);
    end

    // random phase, model compared every cycle
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if ($urandom % 6 == 0) cyc[i] = ~cyc[i];
        if ($urandom % 10 == 0) lock[i] = ~lock[i];
        stb[i] = cyc[i] & 1'($urandom);
        we[i]  = cyc[i] & 1'($urandom);
      end
      randomize_fields();
      sl_ack = 1'($urandom); sl_err = 1'($urandom); sl_rty = 1'($urandom);
      sl_stall = 1'($urandom); sl_rdat = $urandom;
      #1 compare_model();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule